// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the bus-facing register file of an interrupt routing controller. Software never addresses the routing table directly. It first writes an 8-bit index into a select register, then reads or writes a 32-bit data window that exposes whichever internal register the index names. The internal registers are a version word, an identifier, an arbitration word and a table of 64-bit redirection entries, one per input pin. Each entry is reached as two 32-bit halves.

A third bus location accepts end-of-interrupt messages that carry a vector. The block keeps the redirection table itself. It tells the neighbouring delivery logic about the side effects of software activity: service requests after entry writes, end-of-interrupt notifications, and changes to each entry's remote-IRR bit. The delivery logic in turn marks entries as in service through a per-pin set input.

The bus side uses plain single-cycle read and write strobes. Read data is combinational within the strobe cycle, and writes take effect at the clock edge that ends the strobe.

Top module: `irq_route_regwin`

## Requirements
- R1: `bus_hit` is high exactly when a strobe is active and `bus_addr` lies in [BASE, BASE+0x100). Outside that range `bus_rdata` is zero and a write changes no state. `bus_rdata` is zero whenever `bus_rd` is low.
- R2: Offset 0x00 holds the 8-bit select register. A write loads it from `bus_wdata[7:0]`, and a read returns it zero-extended.
- R3: A window read (offset 0x10) with select 0x01 returns NPINS-1 in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Window writes at select 0x01 are ignored.
- R4: Selects 0x00 and 0x02 both read a 4-bit identifier in bits 27:24, with all other bits zero. A window write at select 0x00 stores `bus_wdata[27:24]`, and a write at select 0x02 is ignored. Selects 0x03 to 0x0F read zero.
- R5: For select values of 0x10 and above, the entry index is (select-0x10)>>1. An odd select reaches bits 63:32 of the entry and an even select reaches bits 31:0. Entry bit layout:
  - vector: 7:0
  - delivery mode: 10:8
  - destination mode: 11
  - polarity: 13
  - remote IRR: 14
  - trigger (1 = level): 15
  - mask: 16
  - destination: 63:56
  
  All other bits are stored as written.
- R6: A window read of an entry index at or above NPINS returns 0xFFFFFFFF, and a window write to such an index changes no entry.
- R7: A write to the low half of an entry stores bit 14 as 0, whatever the data says. A write to the high half leaves bit 14 unchanged.
- R8: A pulse on `rirr_set[i]` sets bit 14 of entry i at the next edge. A low-half write to entry i or a matching end-of-interrupt in the same cycle wins, and the bit ends up 0.
- R9: A write at offset 0x40 raises `eoi_pulse` for one cycle after the edge, with `eoi_vector` set to `bus_wdata[7:0]`. It also clears bit 14 of every entry whose vector field equals that value.
- R10: After a window write to entry i, `svc_req[i]` is high for the one cycle following the edge exactly when the entry's new trigger bit is 1 and `pin_irr[i]` was high during the write. At most one `svc_req` bit is high at a time.
- R11: After reset each entry holds only its mask bit: the low half reads 0x00010000 and the high half reads 0. Select and identifier are 0, and `eoi_pulse` and `svc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_hit | output | 1 | Access claimed by this block |
| bus_rdata | output | 32 | Read data, valid during the read strobe |
| pin_irr | input | NPINS | Per-pin request-pending state from the delivery logic |
| rirr_set | input | NPINS | Per-pin pulse that marks an entry as in service |
| svc_req | output | NPINS | Per-pin service request after an entry write |
| eoi_pulse | output | 1 | End-of-interrupt write seen |
| eoi_vector | output | 8 | Vector carried by that end-of-interrupt |

## Verification
The remote-IRR bit of one entry can be set by the delivery logic in the very cycle that software clears it. Software clears it in two ways: by rewriting the entry's low half, or by an end-of-interrupt whose vector matches. The bench raises `rirr_set` for a pin during each kind of clearing write and then reads the entry back through the window. The bit must read 0. Separately, it shows that a set with no competing clear reads back as 1, and that a high-half write does not disturb it.

// File: rtl/irq_route_regwin.sv
module irq_route_regwin #(
  parameter int          NPINS   = 24,
  parameter logic [31:0] BASE    = 32'hFEC0_0000,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [31:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic             bus_hit,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_irr,
  input  logic [NPINS-1:0] rirr_set,
  output logic [NPINS-1:0] svc_req,
  output logic             eoi_pulse,
  output logic [7:0]       eoi_vector
);
  localparam logic [31:0] SPAN     = 32'h100;
  localparam logic [7:0]  OFF_SEL  = 8'h00;
  localparam logic [7:0]  OFF_WIN  = 8'h10;
  localparam logic [7:0]  OFF_EOI  = 8'h40;
  localparam logic [63:0] ENT_RST  = 64'h0000_0000_0001_0000;
  localparam logic [7:0]  LAST_PIN = 8'(NPINS - 1);

  logic [7:0]  sel;
  logic [3:0]  id;
  logic [63:0] ent     [NPINS];
  logic [63:0] ent_nxt [NPINS];
  logic [63:0] ent_sel;
  logic [NPINS-1:0] lo_wr, hi_wr, eoi_hit, svc_nxt;
  logic [31:0] win_rdata;
  logic [6:0]  ridx;
  logic        in_range, is_sel, is_win, is_eoi, tbl_sel, win_wr, eoi_wr;

  assign in_range = (bus_addr & ~(SPAN - 32'd1)) == BASE;
  assign is_sel   = in_range && bus_addr[7:0] == OFF_SEL;
  assign is_win   = in_range && bus_addr[7:0] == OFF_WIN;
  assign is_eoi   = in_range && bus_addr[7:0] == OFF_EOI;
  assign bus_hit  = in_range && (bus_rd || bus_wr);
  assign tbl_sel  = sel >= 8'h10;
  assign ridx     = sel[7:1] - 7'd8;
  assign win_wr   = bus_wr && is_win;
  assign eoi_wr   = bus_wr && is_eoi;

  always_comb begin
    ent_sel = '1;
    for (int i = 0; i < NPINS; i++)
      if (ridx == 7'(i)) ent_sel = ent[i];
  end

  always_comb begin
    win_rdata = '0;
    case (sel)
      8'h00, 8'h02: win_rdata = {4'h0, id, 24'h0};
      8'h01:        win_rdata = {8'h0, LAST_PIN, 8'h0, VERSION};
      default:      if (tbl_sel) win_rdata = sel[0] ? ent_sel[63:32] : ent_sel[31:0];
    endcase
  end

  assign bus_rdata = !bus_rd ? '0 :
                     is_sel  ? {24'h0, sel} :
                     is_win  ? win_rdata : '0;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      lo_wr[i]   = win_wr && tbl_sel && !sel[0] && ridx == 7'(i);
      hi_wr[i]   = win_wr && tbl_sel &&  sel[0] && ridx == 7'(i);
      eoi_hit[i] = eoi_wr && ent[i][7:0] == bus_wdata[7:0];
      ent_nxt[i] = ent[i];
      if (hi_wr[i]) ent_nxt[i][63:32] = bus_wdata;
      if (lo_wr[i]) ent_nxt[i][31:0]  = {bus_wdata[31:15], 1'b0, bus_wdata[13:0]};
      if (rirr_set[i] && !lo_wr[i] && !eoi_hit[i]) ent_nxt[i][14] = 1'b1;
      if (eoi_hit[i]) ent_nxt[i][14] = 1'b0;
      svc_nxt[i] = (lo_wr[i] || hi_wr[i]) && ent_nxt[i][15] && pin_irr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel        <= '0;
      id         <= '0;
      svc_req    <= '0;
      eoi_pulse  <= 1'b0;
      eoi_vector <= '0;
      for (int i = 0; i < NPINS; i++) ent[i] <= ENT_RST;
    end else begin
      if (bus_wr && is_sel) sel <= bus_wdata[7:0];
      if (win_wr && sel == 8'h00) id <= bus_wdata[27:24];
      ent        <= ent_nxt;
      svc_req    <= svc_nxt;
      eoi_pulse  <= eoi_wr;
      if (eoi_wr) eoi_vector <= bus_wdata[7:0];
    end
  end
endmodule

module irq_route_regwin_chk #(
  parameter int          NPINS = 24,
  parameter logic [31:0] BASE  = 32'hFEC0_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [31:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_hit,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] svc_req,
  input logic             eoi_pulse,
  input logic [7:0]       eoi_vector,
  input logic [7:0]       sel
);
  p_hit_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> !bus_hit);
  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 32'h0);
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == BASE) |=> sel == $past(bus_wdata[7:0]));
  p_eoi_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(bus_wr && bus_addr == BASE + 32'h40));
  p_eoi_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> eoi_vector == $past(bus_wdata[7:0]));
  p_svc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req) |-> $past(bus_wr && bus_addr == BASE + 32'h10));
  p_svc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_req));
endmodule

bind irq_route_regwin irq_route_regwin_chk #(.NPINS(NPINS), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_hit(bus_hit), .bus_rdata(bus_rdata), .svc_req(svc_req),
  .eoi_pulse(eoi_pulse), .eoi_vector(eoi_vector), .sel(sel));

// File: tb/irq_route_regwin_tb.sv
`timescale 1ns/1ps
module irq_route_regwin_tb;
  localparam int          NP   = 24;
  localparam logic [31:0] BASE = 32'hFEC0_0000;
  localparam logic [7:0]  VER  = 8'h11;
  localparam logic [31:0] WIN  = BASE + 32'h10;
  localparam logic [31:0] EOI  = BASE + 32'h40;

  logic clk = 0, rst_n = 0, bus_rd = 0, bus_wr = 0, bus_hit, eoi_pulse;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [NP-1:0] pin_irr = 0, rirr_set = 0, svc_req;
  logic [7:0] eoi_vector;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_lo [NP];
  logic [31:0] exp_hi [NP];
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_route_regwin #(.NPINS(NP), .BASE(BASE), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_hit(bus_hit), .bus_rdata(bus_rdata), .pin_irr(pin_irr),
    .rirr_set(rirr_set), .svc_req(svc_req), .eoi_pulse(eoi_pulse), .eoi_vector(eoi_vector));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rdwin(logic [7:0] s, output logic [31:0] d);
    wr(BASE, {24'h0, s});
    rd(WIN, d);
  endtask

  task automatic wrwin(logic [7:0] s, logic [31:0] d);
    wr(BASE, {24'h0, s});
    wr(WIN, d);
  endtask

  task automatic check_table(string req);
    for (int i = 0; i < NP; i++) begin
      rdwin(8'(16 + 2*i), rv); chk(req, rv, exp_lo[i]);
      rdwin(8'(17 + 2*i), rv); chk(req, rv, exp_hi[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11", {eoi_pulse, svc_req}, 0);
    rd(BASE, rv); chk("R11", rv, 0);
    rdwin(8'h00, rv); chk("R11", rv, 0);
    for (int i = 0; i < NP; i++) begin exp_lo[i] = 32'h0001_0000; exp_hi[i] = 0; end
    check_table("R11");

    // R2 select sweep
    for (int v = 0; v < 256; v++) begin
      wr(BASE, 32'hABCD_EF00 | v);
      rd(BASE, rv); chk("R2", rv, v);
    end

    // R3 version, write ignored
    rdwin(8'h01, rv); chk("R3", rv, {8'h0, 8'(NP-1), 8'h0, VER});
    wr(WIN, 32'hFFFF_FFFF);
    rd(WIN, rv); chk("R3", rv, {8'h0, 8'(NP-1), 8'h0, VER});

    // R4 identifier and arbitration
    wrwin(8'h00, 32'h5AFF_FFFF);
    rdwin(8'h00, rv); chk("R4", rv, 32'h0A00_0000);
    rdwin(8'h02, rv); chk("R4", rv, 32'h0A00_0000);
    wrwin(8'h02, 32'h0500_0000);
    rdwin(8'h00, rv); chk("R4", rv, 32'h0A00_0000);
    for (int s = 3; s < 16; s++) begin rdwin(8'(s), rv); chk("R4", rv, 0); end

    // R5 full table sweep, edge-triggered so no service
    for (int i = 0; i < NP; i++) begin
      exp_lo[i] = (32'(i) * 32'h0101_0101) & 32'hFFFF_3FFF;
      exp_hi[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
      wrwin(8'(16 + 2*i), exp_lo[i]);
      chk("R10", svc_req, 0);
      wrwin(8'(17 + 2*i), exp_hi[i]);
    end
    check_table("R5");

    // R6 out-of-range entries
    for (int s = 16 + 2*NP; s < 256; s++) begin
      rdwin(8'(s), rv); chk("R6", rv, 32'hFFFF_FFFF);
      wr(WIN, 32'h0000_0000);
    end
    check_table("R6");

    // R8 set, R7 high write keeps, low write clears
    @(negedge clk); rirr_set[3] = 1; @(negedge clk); rirr_set = 0;
    exp_lo[3] |= 32'h4000;
    rdwin(8'h16, rv); chk("R8", rv, exp_lo[3]);
    exp_hi[3] = 32'h1234_5678; wrwin(8'h17, exp_hi[3]);
    rdwin(8'h16, rv); chk("R7", rv, exp_lo[3]);
    exp_lo[3] = 32'h0000_4003 & ~32'h4000; wrwin(8'h16, 32'h0000_4003);
    rdwin(8'h16, rv); chk("R7", rv, exp_lo[3]);
    // R8 same-cycle: set vs low-half write
    wr(BASE, 32'h1A);
    rirr_set[5] = 1; wr(WIN, 32'h0000_4005); rirr_set = 0;
    exp_lo[5] = 32'h0000_0005;
    rdwin(8'h1A, rv); chk("R8", rv, exp_lo[5]);

    // R9 end of interrupt
    @(negedge clk); rirr_set[2] = 1; rirr_set[7] = 1; @(negedge clk); rirr_set = 0;
    exp_lo[2] |= 32'h4000; exp_lo[7] |= 32'h4000;
    wr(EOI, 32'hFFFF_FF07);
    chk("R9", {eoi_pulse, eoi_vector}, {1'b1, 8'h07});
    exp_lo[7] &= ~32'h4000;
    @(negedge clk); chk("R9", eoi_pulse, 0);
    rdwin(8'h1E, rv); chk("R9", rv, exp_lo[7]);
    rdwin(8'h14, rv); chk("R9", rv, exp_lo[2]);
    // R8 same-cycle: set vs matching end of interrupt
    rirr_set[2] = 1; wr(EOI, 32'h02); rirr_set = 0;
    exp_lo[2] &= ~32'h4000;
    rdwin(8'h14, rv); chk("R8", rv, exp_lo[2]);
    check_table("R9");

    // R10 service requests
    pin_irr = '1;
    for (int i = 0; i < NP; i++) begin
      wr(BASE, 32'(16 + 2*i));
      wr(WIN, 32'h0000_8000 | i); chk("R10", svc_req, NP'(1) << i);
      wr(WIN, 32'h0000_0000 | i); chk("R10", svc_req, 0);
      wr(BASE, 32'(17 + 2*i));
      wr(WIN, 32'h0);             chk("R10", svc_req, 0);
      wr(BASE, 32'(16 + 2*i));
      wr(WIN, 32'h0000_8000 | i);
      wr(BASE, 32'(17 + 2*i));
      wr(WIN, 32'hFF00_0000);     chk("R10", svc_req, NP'(1) << i);
      exp_lo[i] = 32'h0000_8000 | i; exp_hi[i] = 32'hFF00_0000;
    end
    pin_irr = '0;
    wr(BASE, 32'h10); wr(WIN, 32'h0000_8000); chk("R10", svc_req, 0);

    // R1 decode
    wr(BASE, 32'h22);
    bus_rd = 1; bus_addr = BASE + 32'h100; #1;
    chk("R1", {bus_hit, bus_rdata}, 0);
    bus_addr = BASE - 32'h10; #1; chk("R1", {bus_hit, bus_rdata}, 0);
    bus_addr = BASE; #1; chk("R1", {bus_hit, bus_rdata}, {1'b1, 32'h22});
    @(negedge clk); bus_rd = 0;
    wr(BASE + 32'h100, 32'h77);
    rd(BASE, rv); chk("R1", rv, 32'h22);
    wr(BASE - 32'h100 + 32'h10, 32'h0);
    check_table("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule